// File: doc/BRIEF.md
# Aging-Counter Page Replacement Selector

This block approximates least-recently-used replacement for a set of page frames. Each frame owns a short history register. Whenever a frame is touched, an access strobe marks it as referenced. On every aging tick, all history registers slide one place toward the least significant bit. A frame referenced since the previous tick receives a 1 in its most significant bit, and every other frame receives a 0. A larger register value therefore means more recent use.

When the fault handler needs a frame to evict, it pulses a victim request. On the following cycle the block returns the index of the frame with the smallest history value, together with a one-cycle valid flag. When a new page is loaded into a frame, the reload strobe presets that frame's history as if it had just been accessed. Disk transfer and page-table maintenance happen outside this block.

Top module: `page_age_selector`

## Requirements
- R1: While rst_n is low, every history register and reference bit clears and victim_valid_o is 0. A request made straight after reset returns frame 0.
- R2: An access strobe with no tick only sets the frame's reference bit. No history value changes until the next tick, so a request before that tick still sees the old ordering.
- R3: On a cycle with tick_i high, each frame not being reloaded takes {ref, age[AGE_W-1:1]} and its reference bit clears. Here ref is the stored reference bit ORed with that frame's access strobe in the same cycle.
- R4: On a cycle with reload_i high, frame reload_idx_i takes history 1 followed by AGE_W-1 zeros (100 by default) and its reference bit clears. This takes priority over a tick or access on the same frame in that cycle. An index at or above NUM_FRAMES is ignored.
- R5: A cycle with victim_req_i high causes victim_valid_o to be 1 on the next cycle. victim_idx_o then names a frame whose history value, as it stood in the request cycle before that cycle's update, is the smallest of all frames.
- R6: When several frames share the smallest history value, the lowest-numbered of them is reported.
- R7: victim_valid_o is 0 in any cycle whose preceding cycle had no request. victim_idx_o holds its last value while no request is made.
- R8: A frame that is not accessed or reloaded for AGE_W ticks reaches history 0 and then stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_i | input | NUM_FRAMES | Per-frame access strobes |
| tick_i | input | 1 | Aging tick |
| reload_i | input | 1 | A new page was loaded into a frame |
| reload_idx_i | input | IDX_W | Frame that was reloaded |
| victim_req_i | input | 1 | Request for an eviction victim |
| victim_idx_o | output | IDX_W | Selected victim frame |
| victim_valid_o | output | 1 | victim_idx_o answers the previous cycle's request |

## Verification
The bench targets the following corner cases:
- **Tick and access in the same cycle.** A design that dropped the simultaneous access would age that frame to the bottom and evict it.
- **Tick and reload on the same frame.** A design that let the tick win would leave the reloaded frame at a shifted value rather than 100.
- **Ties.** A design that used a non-strict compare in the minimum scan would return the highest-numbered tied frame instead of the lowest.
- **Access without a tick.** A design that shifted history on every access would reorder frames early.
- **Decay to zero.** A design that failed to clear the reference bit after a tick would never let a frame decay.

// File: rtl/page_age_pkg.sv
package page_age_pkg;

  // Per-frame update selected for one cycle.
  typedef enum logic [1:0] {
    FOP_HOLD   = 2'd0,
    FOP_TICK   = 2'd1,
    FOP_RELOAD = 2'd2
  } frame_op_e;

endpackage

// File: rtl/age_frame_cell.sv
module age_frame_cell
  import page_age_pkg::*;
#(
  parameter int AGE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_i,
  input  frame_op_e        op_i,
  output logic [AGE_W-1:0] age_o
);

  localparam logic [AGE_W-1:0] FRESH_AGE = {1'b1, {(AGE_W-1){1'b0}}};

  logic [AGE_W-1:0] age_q, age_d;
  logic             ref_q, ref_d;
  logic             age_en;
  logic             seen;

  always_comb begin
    seen   = ref_q | access_i;
    age_d  = age_q;
    ref_d  = seen;
    age_en = 1'b0;
    unique case (op_i)
      FOP_RELOAD: begin
        age_d  = FRESH_AGE;
        ref_d  = 1'b0;
        age_en = 1'b1;
      end
      FOP_TICK: begin
        age_d  = {seen, age_q[AGE_W-1:1]};
        ref_d  = 1'b0;
        age_en = 1'b1;
      end
      default: begin
        age_d  = age_q;
        ref_d  = seen;
        age_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      ref_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      if (age_en) begin
        age_q <= age_d;
      end
    end
  end

  assign age_o = age_q;

endmodule

// File: rtl/age_min_select.sv
module age_min_select #(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 3,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic [NUM_FRAMES*AGE_W-1:0] age_flat_i,
  output logic [IDX_W-1:0]            min_idx_o
);

  logic [AGE_W-1:0] best_age;
  logic [AGE_W-1:0] cand_age;

  // Strict compare keeps the lowest index among equal minima.
  always_comb begin
    best_age  = age_flat_i[AGE_W-1:0];
    min_idx_o = '0;
    cand_age  = '0;
    for (int i = 1; i < NUM_FRAMES; i++) begin
      cand_age = age_flat_i[i*AGE_W +: AGE_W];
      if (cand_age < best_age) begin
        best_age  = cand_age;
        min_idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/page_age_selector.sv
module page_age_selector
  import page_age_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 3,
  localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FRAMES-1:0] access_i,
  input  logic                  tick_i,
  input  logic                  reload_i,
  input  logic [IDX_W-1:0]      reload_idx_i,
  input  logic                  victim_req_i,
  output logic [IDX_W-1:0]      victim_idx_o,
  output logic                  victim_valid_o
);

  logic [NUM_FRAMES*AGE_W-1:0] age_flat;
  frame_op_e                   frame_op [NUM_FRAMES];
  logic [IDX_W-1:0]            min_idx;

  logic [IDX_W-1:0] victim_idx_q, victim_idx_d;
  logic             victim_valid_q, victim_valid_d;
  logic             victim_idx_en;

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    always_comb begin
      if (reload_i && (reload_idx_i == IDX_W'(f))) begin
        frame_op[f] = FOP_RELOAD;
      end else if (tick_i) begin
        frame_op[f] = FOP_TICK;
      end else begin
        frame_op[f] = FOP_HOLD;
      end
    end

    age_frame_cell #(
      .AGE_W (AGE_W)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .access_i (access_i[f]),
      .op_i     (frame_op[f]),
      .age_o    (age_flat[f*AGE_W +: AGE_W])
    );
  end

  age_min_select #(
    .NUM_FRAMES (NUM_FRAMES),
    .AGE_W      (AGE_W),
    .IDX_W      (IDX_W)
  ) u_min (
    .age_flat_i (age_flat),
    .min_idx_o  (min_idx)
  );

  always_comb begin
    victim_valid_d = victim_req_i;
    victim_idx_en  = victim_req_i;
    victim_idx_d   = min_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_valid_q <= 1'b0;
      victim_idx_q   <= '0;
    end else begin
      victim_valid_q <= victim_valid_d;
      if (victim_idx_en) begin
        victim_idx_q <= victim_idx_d;
      end
    end
  end

  assign victim_idx_o   = victim_idx_q;
  assign victim_valid_o = victim_valid_q;

endmodule

// File: rtl/page_age_selector_chk.sv
module page_age_selector_chk #(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 3,
  localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reload_i,
  input logic [IDX_W-1:0]            reload_idx_i,
  input logic                        victim_req_i,
  input logic [IDX_W-1:0]            victim_idx_o,
  input logic                        victim_valid_o,
  input logic [NUM_FRAMES*AGE_W-1:0] age_flat
);

  localparam logic [AGE_W-1:0] FRESH_AGE = {1'b1, {(AGE_W-1){1'b0}}};

  logic [NUM_FRAMES*AGE_W-1:0] prev_age;
  logic [IDX_W-1:0]            prev_reload_idx;
  logic                        smaller_found;
  logic                        equal_lower_found;
  logic [AGE_W-1:0]            chosen_age;
  logic [AGE_W-1:0]            reloaded_age;

  always_ff @(posedge clk) begin
    prev_age        <= age_flat;
    prev_reload_idx <= reload_idx_i;
  end

  always_comb begin
    smaller_found     = 1'b0;
    equal_lower_found = 1'b0;
    chosen_age        = '0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (victim_idx_o == IDX_W'(i)) chosen_age = prev_age[i*AGE_W +: AGE_W];
    end
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (prev_age[i*AGE_W +: AGE_W] < chosen_age) smaller_found = 1'b1;
      if ((prev_age[i*AGE_W +: AGE_W] == chosen_age) && (IDX_W'(i) < victim_idx_o))
        equal_lower_found = 1'b1;
    end
    reloaded_age = '0;
    for (int i = 0; i < NUM_FRAMES; i++) begin
      if (prev_reload_idx == IDX_W'(i)) reloaded_age = age_flat[i*AGE_W +: AGE_W];
    end
  end

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    victim_req_i |=> victim_valid_o); // R5

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_req_i |=> !victim_valid_o); // R7

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid_o |-> (int'(victim_idx_o) < NUM_FRAMES)); // R5

  AST_VICTIM_IS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid_o |-> !smaller_found); // R5

  AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid_o |-> !equal_lower_found); // R6

  AST_RELOAD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && (int'(reload_idx_i) < NUM_FRAMES)) |=> (reloaded_age == FRESH_AGE)); // R4

endmodule

bind page_age_selector page_age_selector_chk #(
  .NUM_FRAMES (NUM_FRAMES),
  .AGE_W      (AGE_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reload_i       (reload_i),
  .reload_idx_i   (reload_idx_i),
  .victim_req_i   (victim_req_i),
  .victim_idx_o   (victim_idx_o),
  .victim_valid_o (victim_valid_o),
  .age_flat       (age_flat)
);

// File: tb/page_age_selector_test.sv
module page_age_selector_test;

  localparam int CLK_PERIOD = 10;
  localparam int NF         = 8;
  localparam int W          = 3;
  localparam int IW         = $clog2(NF);
  localparam int WATCHDOG   = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] access_i;
  logic          tick_i;
  logic          reload_i;
  logic [IW-1:0] reload_idx_i;
  logic          victim_req_i;
  logic [IW-1:0] victim_idx_o;
  logic          victim_valid_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  // Behavioural reference state
  int m_age [NF];
  bit m_ref [NF];
  bit exp_valid = 1'b0;
  int exp_idx   = 0;

  page_age_selector #(.NUM_FRAMES(NF), .AGE_W(W)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .access_i       (access_i),
    .tick_i         (tick_i),
    .reload_i       (reload_i),
    .reload_idx_i   (reload_idx_i),
    .victim_req_i   (victim_req_i),
    .victim_idx_o   (victim_idx_o),
    .victim_valid_o (victim_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, actual, expected, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Reference model: evaluated at each rising edge from the driven inputs.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NF; f++) begin m_age[f] = 0; m_ref[f] = 0; end
      exp_valid = 0;
    end else begin
      exp_valid = victim_req_i;
      if (victim_req_i) begin
        int best;
        best = 0;
        for (int f = 1; f < NF; f++) if (m_age[f] < m_age[best]) best = f;
        exp_idx = best;
      end
      for (int f = 0; f < NF; f++) begin
        bit seen;
        seen = m_ref[f] | access_i[f];
        if (reload_i && int'(reload_idx_i) == f) begin
          m_age[f] = 1 << (W-1); m_ref[f] = 0;
        end else if (tick_i) begin
          m_age[f] = (int'(seen) << (W-1)) | (m_age[f] >> 1); m_ref[f] = 0;
        end else begin
          m_ref[f] = seen;
        end
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      check(int'(victim_valid_o), int'(exp_valid), "R7 model valid");
      if (exp_valid) check(int'(victim_idx_o), exp_idx, "R5 model victim");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic idle_inputs();
    access_i = '0; tick_i = 0; reload_i = 0; reload_idx_i = '0; victim_req_i = 0;
  endtask

  task automatic tick_with(input logic [NF-1:0] mask);
    @(negedge clk); access_i = mask; tick_i = 1;
    @(negedge clk); idle_inputs();
  endtask

  task automatic ask(input int expected, input string tag);
    @(negedge clk); victim_req_i = 1;
    @(negedge clk); victim_req_i = 0;
    check(int'(victim_valid_o), 1, tag);
    check(int'(victim_idx_o), expected, tag);
  endtask

  localparam logic [NF-1:0] HIGH5 = 8'b1111_1000;

  initial begin
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check(int'(victim_valid_o), 0, "R1 valid in reset");
    rst_n = 1;
    @(negedge clk);
    check(int'(victim_valid_o), 0, "R1 valid after reset");
    ask(0, "R1 first victim");

    // Documented ordering: frames 0,1,2,1 each followed by a tick; 3..7 kept hot.
    tick_with(HIGH5 | 8'b001);
    tick_with(HIGH5 | 8'b010);
    tick_with(HIGH5 | 8'b100);
    tick_with(HIGH5 | 8'b010);
    ask(0, "R3 aging order victim 0");

    // Access frame 0 without tick: ordering unchanged.
    @(negedge clk); access_i = 8'b001;
    @(negedge clk); idle_inputs();
    ask(0, "R2 access without tick");

    // Tick consumes stored reference: f0=100 f1=010 f2=001.
    tick_with(HIGH5);
    ask(2, "R3 latched ref consumed");

    // Reload frame 2 -> 100; f1=010 is lowest.
    @(negedge clk); reload_i = 1; reload_idx_i = 3'd2;
    @(negedge clk); idle_inputs();
    ask(1, "R4 reload fresh age");

    // f0=010 f1=001 f2=010
    tick_with(HIGH5);
    ask(1, "R5 unique minimum");
    // f0=001 f1=000 f2=001, then all three 000
    tick_with(HIGH5);
    tick_with(HIGH5);
    ask(0, "R6 tie lowest index");
    tick_with(HIGH5);
    ask(0, "R8 stays at zero");

    // Reload frame 0 with a tick in the same cycle: f0=100 f1=000 f2=000.
    @(negedge clk); reload_i = 1; reload_idx_i = 3'd0; tick_i = 1; access_i = HIGH5;
    @(negedge clk); idle_inputs();
    ask(1, "R4 reload beats tick");

    // Access coinciding with tick: f0=010 f1=100 f2=000.
    tick_with(HIGH5 | 8'b010);
    ask(2, "R3 access on tick edge");

    // No request: valid must stay low.
    @(negedge clk);
    check(int'(victim_valid_o), 0, "R7 no request");
    check(int'(victim_idx_o), 2, "R7 index held");

    // Random traffic compared against the model each clock.
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      access_i     = NF'($urandom) & NF'($urandom);
      tick_i       = ($urandom % 4) == 0;
      reload_i     = ($urandom % 8) == 0;
      reload_idx_i = IW'($urandom);
      victim_req_i = ($urandom % 3) == 0;
    end
    @(negedge clk); idle_inputs();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule